// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block converts a single PWM command into two gate-enable signals, one for the high-side switch and one for the low-side switch of a synchronous buck stage. It inserts a dead time between the two and never drives both enables high at once. When enabled, the high-side enable follows the PWM level and the low-side enable follows its inverse. An active-low disable input forces both enables low.

The dead time from high-side off to low-side on adapts to the switch node. Two digital comparator flags report whether the node is high and whether it has fallen below about 1 V. If the node was never seen high, a fixed fallback delay replaces the threshold watch. A timeout forces the low side on if the node never drops, which happens when inductor current flows in reverse. The dead time from low-side off to high-side on waits for a third flag, which reports that the low-side gate has discharged, and then adds a short settle delay. All delays are parameters counted in clock cycles.

Top module: `gdt_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never both high in the same cycle.
- R2: A low `dis_n` forces both enables low on the third rising edge after it is applied, and keeps them low while it stays low.
- R3: Every input passes a two-flop synchronizer, and the outputs are registered. A PWM fall reaches `hs_en` on the third rising edge. With PWM held high and the sequence complete, `hs_en`=1 and `ls_en`=0. With PWM held low, `hs_en`=0 and `ls_en`=1.
- R4: If `node_hi` was seen at any edge of the preceding high-side on-period, the low side turns on one edge after the synchronized `node_low` flag is observed during the gap. A `node_low` raised at a falling edge therefore turns the low side on 3 cycles later.
- R5: If `node_hi` was not seen during the high-side on-period, `ls_en` rises exactly FALLBACK_CYC cycles after `hs_en` falls, whatever `node_low` does.
- R6: If `node_hi` was seen but `node_low` never asserts, `ls_en` rises exactly TIMEOUT_CYC cycles after `hs_en` falls.
- R7: When PWM rises, `ls_en` falls on the third edge. `hs_en` stays low while `lg_off` is low. Once `lg_off` rises, `hs_en` rises 3+SETTLE_CYC cycles later.
- R8: If PWM reverses while a dead-time wait is pending, the pending turn-on never happens, and the opposite transition starts from the all-off state. After a high-to-low gap is abandoned, the next low-side turn-on takes the fallback path.
- R9: Reset and disable both leave the controller all-off. At the first PWM evaluation after that, a low level takes the fallback path of R5 and a high level takes the discharge path of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| dis_n | input | 1 | Active-low output disable, asynchronous |
| node_hi | input | 1 | Comparator flag: switch node is high |
| node_low | input | 1 | Comparator flag: switch node below about 1 V |
| lg_off | input | 1 | Comparator flag: low-side gate discharged |
| hs_en | output | 1 | High-side gate enable, registered |
| ls_en | output | 1 | Low-side gate enable, registered |

## Verification
The assertions assume nothing about the comparator flags. They must hold for any mix of flag levels, including levels that contradict each other or the gate state, so the stimulus drives each flag independently at random. PWM and disable levels are held for random lengths, some shorter than the dead-time windows, so that abandoned waits and disables in mid-gap occur often. Directed segments measure each delay path in cycles with the flags held steady around the measured edge.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_HI_ON     = 3'd1,
        PH_HL_GAP    = 3'd2,
        PH_LO_ON     = 3'd3,
        PH_LH_WAIT   = 3'd4,
        PH_LH_SETTLE = 3'd5
    } phase_e;

    typedef struct packed {
        logic pwm;
        logic run;
        logic node_hi;
        logic node_low;
        logic lgate_off;
    } sense_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    localparam int unsigned SENSE_W = $bits(sense_t);

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned width_for(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic gate_t gate_of(input phase_e ph);
        gate_t g;
        g.hi = (ph == PH_HI_ON);
        g.lo = (ph == PH_LO_ON);
        return g;
    endfunction

endpackage

// File: rtl/gdt_sync.sv
module gdt_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/gdt_timer.sv
module gdt_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)    cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/gdt_seq.sv
module gdt_seq
    import gdt_pkg::*;
#(
    parameter int unsigned FALLBACK_CYC = 19,
    parameter int unsigned TIMEOUT_CYC  = 24,
    parameter int unsigned SETTLE_CYC   = 3,
    parameter int unsigned CW           = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  sense_t        s,
    input  logic [CW-1:0] cnt,
    output logic          tmr_clr,
    output gate_t         gate
);
    localparam logic [CW-1:0] FB_LAST = CW'(FALLBACK_CYC - 1);
    localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] ST_LAST = CW'(SETTLE_CYC - 1);

    phase_e phase, nxt;
    logic   seen, seen_nxt;
    logic   gap_done;

    always_comb begin
        if (seen) gap_done = s.node_low || (cnt == TO_LAST);
        else      gap_done = (cnt == FB_LAST);
    end

    always_comb begin
        nxt = phase;
        if (!s.run) begin
            nxt = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:      nxt = s.pwm ? PH_LH_WAIT : PH_HL_GAP;
                PH_HI_ON:     if (!s.pwm) nxt = PH_HL_GAP;
                PH_HL_GAP: begin
                    if (s.pwm)         nxt = PH_LH_WAIT;
                    else if (gap_done) nxt = PH_LO_ON;
                end
                PH_LO_ON:     if (s.pwm) nxt = PH_LH_WAIT;
                PH_LH_WAIT: begin
                    if (!s.pwm)          nxt = PH_HL_GAP;
                    else if (s.lgate_off) nxt = PH_LH_SETTLE;
                end
                PH_LH_SETTLE: begin
                    if (!s.pwm)             nxt = PH_HL_GAP;
                    else if (cnt == ST_LAST) nxt = PH_HI_ON;
                end
                default:      nxt = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_HI_ON:  seen_nxt = seen | s.node_hi;
            PH_HL_GAP: seen_nxt = seen;
            default:   seen_nxt = 1'b0;
        endcase
    end

    assign tmr_clr = (nxt != phase) ||
                     !((phase == PH_HL_GAP) || (phase == PH_LH_SETTLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            seen  <= 1'b0;
            gate  <= '0;
        end else begin
            phase <= nxt;
            seen  <= seen_nxt;
            gate  <= gate_of(nxt);
        end
    end

    // R5 / R6: the gap counter never passes the limit of its active path
    p_gap_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HL_GAP) |-> (cnt <= (seen ? TO_LAST : FB_LAST)));

    // R4: a low-side turn-on always comes out of the high-to-low gap
    p_lo_from_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.lo) |-> ($past(phase) == PH_HL_GAP));

    // R7: a high-side turn-on always comes out of the settle wait
    p_hi_from_settle_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.hi) |-> ($past(phase) == PH_LH_SETTLE));
endmodule

// File: rtl/gdt_ctrl.sv
module gdt_ctrl
    import gdt_pkg::*;
#(
    parameter int unsigned FALLBACK_CYC = 19,
    parameter int unsigned TIMEOUT_CYC  = 24,
    parameter int unsigned SETTLE_CYC   = 3,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic dis_n,
    input  logic node_hi,
    input  logic node_low,
    input  logic lg_off,
    output logic hs_en,
    output logic ls_en
);
    localparam int unsigned CW = width_for(max3(FALLBACK_CYC, TIMEOUT_CYC, SETTLE_CYC));

    sense_t        raw, s;
    logic [CW-1:0] cnt;
    logic          tmr_clr;
    gate_t         gate;

    assign raw = '{pwm: pwm_in, run: dis_n, node_hi: node_hi,
                   node_low: node_low, lgate_off: lg_off};

    gdt_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(raw), .q(s)
    );

    gdt_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(cnt)
    );

    gdt_seq #(
        .FALLBACK_CYC(FALLBACK_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
        .SETTLE_CYC(SETTLE_CYC), .CW(CW)
    ) seq_i (
        .clk(clk), .rst(rst), .s(s), .cnt(cnt), .tmr_clr(tmr_clr), .gate(gate)
    );

    assign hs_en = gate.hi;
    assign ls_en = gate.lo;

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    p_disable_off_r2: assert property (@(posedge clk) disable iff (rst)
        !s.run |=> (!hs_en && !ls_en));

    p_ls_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> !$past(hs_en));

    p_hs_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> !$past(ls_en));
endmodule

// File: tb/gdt_ctrl_tb.sv
module gdt_ctrl_tb_top;
    localparam int FB = 19;
    localparam int TO = 24;
    localparam int ST = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0, dis_n = 1'b0, node_hi = 1'b0, node_low = 1'b0, lg_off = 1'b0;
    logic hs_en, ls_en;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    gdt_ctrl dut_i (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .dis_n(dis_n), .node_hi(node_hi),
        .node_low(node_low), .lg_off(lg_off), .hs_en(hs_en), .ls_en(ls_en)
    );

    // behavioural model of the requirements
    localparam int M_IDLE = 0, M_HI = 1, M_GAP = 2, M_LO = 3, M_WAIT = 4, M_SET = 5;
    int   m_st = M_IDLE, m_cnt = 0;
    logic m_seen = 0, m_hs = 0, m_ls = 0, m_en = 0;
    logic [4:0] q1 = '0, q2 = '0;

    function automatic int next_state(input int st, input int cnt, input logic seen,
                                      input logic [4:0] v);
        logic pw, en, slo, lgo;
        {pw, en, slo, lgo} = {v[4], v[3], v[1], v[0]};
        if (!en) return M_IDLE;
        case (st)
            M_IDLE: return pw ? M_WAIT : M_GAP;
            M_HI:   return pw ? M_HI : M_GAP;
            M_GAP:  if (pw) return M_WAIT;
                    else if (seen ? (slo || cnt == TO - 1) : (cnt == FB - 1)) return M_LO;
                    else return M_GAP;
            M_LO:   return pw ? M_WAIT : M_LO;
            M_WAIT: if (!pw) return M_GAP; else return lgo ? M_SET : M_WAIT;
            M_SET:  if (!pw) return M_GAP; else return (cnt == ST - 1) ? M_HI : M_SET;
            default: return M_IDLE;
        endcase
    endfunction

    always @(posedge clk) begin
        int ns;
        if (rst) begin
            m_st = M_IDLE; m_cnt = 0; m_seen = 0; m_hs = 0; m_ls = 0;
            q1 = '0; q2 = '0; m_en = 0;
        end else begin
            m_en = q2[3];
            ns = next_state(m_st, m_cnt, m_seen, q2);
            if (m_st == M_HI)       m_seen = m_seen | q2[2];
            else if (m_st != M_GAP) m_seen = 0;
            m_cnt = (ns != m_st) ? 0 : m_cnt + 1;
            m_st = ns;
            m_hs = (ns == M_HI);
            m_ls = (ns == M_LO);
            q2 = q1;
            q1 = {pwm_in, dis_n, node_hi, node_low, lg_off};
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    bit cmp_on = 0;
    always @(negedge clk) begin
        cyc++;
        if (cmp_on && !rst) begin
            string tag;
            if (!m_en)                                   tag = "R2";
            else if (m_st == M_IDLE)                     tag = "R9";
            else if (m_st == M_GAP)                      tag = m_seen ? "R4" : "R5";
            else if (m_st == M_WAIT || m_st == M_SET)    tag = "R7";
            else                                         tag = "R3";
            check(!(hs_en && ls_en), "R1 overlap", 1, 0);
            check({hs_en, ls_en} == {m_hs, m_ls}, tag, {hs_en, ls_en}, {m_hs, m_ls});
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_hs_low();
        int g = 0;
        while (hs_en && g < 100) begin @(negedge clk); g++; end
    endtask

    task automatic count_until(input bit want_hs, output int n);
        n = 0;
        while ((want_hs ? !hs_en : !ls_en) && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        check(0, "watchdog", cyc, 150000);
        finish_run();
    end

    initial begin
        int n, sawls;
        void'($urandom(32'd4242));
        ticks(4);
        check(!hs_en && !ls_en, "R9 reset", {hs_en, ls_en}, 0);
        rst = 1'b0; dis_n = 1'b1; cmp_on = 1;
        ticks(40);
        check(ls_en == 1, "R9 first eval low", ls_en, 1);

        // R7: rising path waits for discharge, then settle
        lg_off = 0; pwm_in = 1; ticks(3);
        check(!ls_en && !hs_en, "R7 ls off", {hs_en, ls_en}, 0);
        ticks(20);
        check(!hs_en, "R7 hold without discharge", hs_en, 0);
        lg_off = 1; count_until(1, n);
        check(n == 3 + ST, "R7 settle", n, 3 + ST);

        // R4: node seen high, then falls below threshold
        node_hi = 1; node_low = 0; ticks(10);
        pwm_in = 0; n = 0;
        while (hs_en && n < 50) begin @(negedge clk); n++; end
        check(n == 3, "R3 fall latency", n, 3);
        node_hi = 0; node_low = 1; count_until(0, n);
        check(n == 3, "R4 threshold", n, 3);

        // R5: node never seen high
        pwm_in = 1; ticks(20); pwm_in = 0; wait_hs_low(); count_until(0, n);
        check(n == FB, "R5 fallback", n, FB);

        // R6: seen high, never drops
        node_hi = 1; node_low = 0; pwm_in = 1; ticks(20);
        pwm_in = 0; wait_hs_low(); node_hi = 0; count_until(0, n);
        check(n == TO, "R6 timeout", n, TO);

        // R8: reversal mid-gap
        pwm_in = 1; ticks(20); pwm_in = 0; wait_hs_low(); ticks(5);
        pwm_in = 1; sawls = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (ls_en) sawls = 1; end
        check(sawls == 0, "R8 abandoned ls", sawls, 0);
        check(hs_en == 1, "R8 hs back", hs_en, 1);

        // R2: disable in mid on-period
        dis_n = 0; ticks(3);
        check(!hs_en && !ls_en, "R2 disable", {hs_en, ls_en}, 0);
        ticks(10);
        check(!hs_en && !ls_en, "R2 disable hold", {hs_en, ls_en}, 0);
        dis_n = 1; ticks(20);
        check(hs_en == 1, "R9 release high", hs_en, 1);

        // random segments
        for (int seg = 0; seg < 500; seg++) begin
            int len;
            pwm_in = $urandom_range(0, 1);
            dis_n  = ($urandom_range(0, 19) != 0);
            len    = $urandom_range(1, 60);
            for (int i = 0; i < len; i++) begin
                node_hi  = $urandom_range(0, 1);
                node_low = ($urandom_range(0, 7) == 0);
                lg_off   = $urandom_range(0, 1);
                @(negedge clk);
            end
        end
        finish_run();
    end
endmodule